// File: doc/BRIEF.md
# Mode-Steered I/O Port Control

This block holds the configuration state of three 8-bit I/O ports in a small
accumulator-based controller. Each port owns a set of control registers: a
direction register that decides which pins drive, plus auxiliary registers
whose meaning belongs to the pad ring. One port-control opcode writes the
accumulator (W) into one of these registers. A 4-bit selector register picks
which one. The selector is loaded from a literal in the opcode or from W, and
it can be copied back into W.

The core's fetch stage sends the raw 12-bit instruction word with a valid
strobe. The block decodes the four opcodes it owns and ignores every other
word. Each of these instructions completes in one cycle and leaves the status
flags alone. The block also serves the operand path: when the core reads one
of the three port file addresses, the block returns the levels actually seen
on the pins, not the output latch contents. A read-modify-write on a port
therefore starts from the real pin state.

Top module: `mps_port_ctrl`

## Requirements
- R1: After reset every direction bit is 1, so all pins are high impedance. The selector holds 0, the value that selects the direction register. Every auxiliary control register holds 0.
- R2: The port-control opcode has the form 12'b0000_0000_0fff. With f = 5, 6 or 7 and a selector value m below 4, it writes W into control register m of port f-5 at the next clock edge. Register index 0 is the direction register and indices 1 to 3 are auxiliary. No other control register changes.
- R3: The port-control opcode does not write any register when f is outside 5..7 or when the selector value is 4 or more.
- R4: A direction bit of 1 turns off the output driver of its pin: `pin_oe` is 0 and `pin_dout` is 0. A direction bit of 0 sets `pin_oe` to 1, and `pin_dout` follows the output latch bit.
- R5: The load-selector-literal opcode 12'b0000_0101_nnnn sets the selector to nnnn at the next edge.
- R6: The load-selector-from-W opcode 12'h043 sets the selector to W[3:0] at the next edge. W[7:4] is discarded.
- R7: The read-selector opcode 12'h042 raises `w_we` in the same cycle, with `w_wdata` = {4'b0000, selector}. For every other word, `w_we` is 0.
- R8: When `rd_addr` is 5, 6 or 7, `rd_hit` is 1 and `rd_data` equals the pin input bits of port `rd_addr`-5, whatever the output latch holds. For any other address, `rd_hit` and `rd_data` are 0.
- R9: The selector and the control registers change only when `instr_vld` is 1 and the word is one of the opcodes above. Every other word, and any cycle with `instr_vld` at 0, leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction word is executing this cycle |
| instr | input | 12 | Raw instruction word |
| w_in | input | 8 | Accumulator value |
| rd_addr | input | 5 | File address of the operand read |
| pin_in | input | 24 | Pin input levels, port 0 in bits 7:0 |
| out_latch | input | 24 | Output latch values, same packing |
| mode_q | output | 4 | Selector register |
| ctrl_q | output | 96 | Control registers; port p, index r at bits ((p*4)+r)*8 +: 8 |
| pin_oe | output | 24 | Output driver enable per pin |
| pin_dout | output | 24 | Gated output data per pin |
| w_we | output | 1 | Write strobe for W |
| w_wdata | output | 8 | Data for W |
| rd_hit | output | 1 | Operand address is a port |
| rd_data | output | 8 | Pin levels of the addressed port |

## Verification
The assertions check four things on every cycle. Each pin's driver enable and data must be the inverse of its direction bit. A literal or W load must reach the selector one cycle later. The selector must hold when no selector opcode arrives, and the control registers must not move while `instr_vld` is low. The W copy must carry a zero high nibble, and a port read that misses must return zero. Other properties need the bench's scenarios to show them. These include steering a control write to exactly one register under each selector value, and dropping writes for out-of-range f or selector values. They also include reading pin levels that disagree with the latches, and the complete reset contents.

// File: rtl/mps_pkg.sv
package mps_pkg;

   localparam int INSTR_W = 12;
   localparam int SEL_W   = 4;
   localparam int WORD_W  = 8;

   localparam logic [INSTR_W-1:0] OPC_SEL_FROM_W = 12'h043;
   localparam logic [INSTR_W-1:0] OPC_SEL_TO_W   = 12'h042;
   localparam logic [8:0]         OPC_PCTL_HI    = 9'b0000_0000_0;
   localparam logic [7:0]         OPC_SEL_LIT_HI = 8'b0000_0101;

   typedef struct packed {
      logic             pctl;
      logic [2:0]       pctl_f;
      logic             sel_lit;
      logic [SEL_W-1:0] sel_lit_val;
      logic             sel_from_w;
      logic             sel_to_w;
   } op_t;

   function automatic op_t decode_op(input logic vld, input logic [INSTR_W-1:0] iw);
      op_t o;
      o.pctl        = vld && (iw[11:3] == OPC_PCTL_HI);
      o.pctl_f      = iw[2:0];
      o.sel_lit     = vld && (iw[11:4] == OPC_SEL_LIT_HI);
      o.sel_lit_val = iw[SEL_W-1:0];
      o.sel_from_w  = vld && (iw == OPC_SEL_FROM_W);
      o.sel_to_w    = vld && (iw == OPC_SEL_TO_W);
      return o;
   endfunction

endpackage

// File: rtl/mps_decode.sv
module mps_decode
   import mps_pkg::*;
#(
   parameter int NUM_PORT   = 3,
   parameter int FIRST_ADDR = 5
) (
   input  logic                instr_vld,
   input  logic [INSTR_W-1:0]  instr,
   output op_t                 op,
   output logic [NUM_PORT-1:0] port_wsel
);

   assign op = decode_op(instr_vld, instr);

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_psel
      localparam logic [2:0] ADDR = 3'(FIRST_ADDR + p);
      assign port_wsel[p] = op.pctl && (op.pctl_f == ADDR);
   end

endmodule

// File: rtl/mps_mode_reg.sv
module mps_mode_reg
   import mps_pkg::*;
#(
   parameter logic [SEL_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lit,
   input  logic [SEL_W-1:0]  lit_val,
   input  logic              ld_w,
   input  logic [WORD_W-1:0] w_val,
   output logic [SEL_W-1:0]  sel_q
);

   logic [SEL_W-1:0] nxt;

   always_comb begin
      nxt = sel_q;
      if (ld_lit)    nxt = lit_val;
      else if (ld_w) nxt = w_val[SEL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= RST_VAL;
      else        sel_q <= nxt;
   end

endmodule

// File: rtl/mps_ctrl_bank.sv
module mps_ctrl_bank
   import mps_pkg::*;
#(
   parameter int                 NUM_CTRL = 4,
   parameter int                 DIR_IDX  = 0,
   parameter logic [WORD_W-1:0]  AUX_RST  = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           sel,
   input  logic [WORD_W-1:0]          wdata,
   output logic [NUM_CTRL*WORD_W-1:0] regs_q,
   output logic [WORD_W-1:0]          dir_q
);

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_reg
      localparam logic [WORD_W-1:0] RST = (r == DIR_IDX) ? '1 : AUX_RST;
      logic hit;
      logic [WORD_W-1:0] q;
      assign hit = wr_en && (32'(sel) == r);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= RST;
         else if (hit) q <= wdata;
      end
      assign regs_q[r*WORD_W +: WORD_W] = q;
   end

   assign dir_q = regs_q[DIR_IDX*WORD_W +: WORD_W];

endmodule

// File: rtl/mps_read_mux.sv
module mps_read_mux
   import mps_pkg::*;
#(
   parameter int NUM_PORT   = 3,
   parameter int FIRST_ADDR = 5,
   parameter int ADDR_W     = 5
) (
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [NUM_PORT*WORD_W-1:0] pin_in,
   output logic                       rd_hit,
   output logic [WORD_W-1:0]          rd_data
);

   logic [NUM_PORT-1:0] hit_v;
   logic [WORD_W-1:0]   term [NUM_PORT];

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_rd
      assign hit_v[p] = (32'(rd_addr) == FIRST_ADDR + p);
      assign term[p]  = hit_v[p] ? pin_in[p*WORD_W +: WORD_W] : '0;
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PORT; p++) rd_data = rd_data | term[p];
   end

   assign rd_hit = |hit_v;

endmodule

// File: rtl/mps_port_ctrl.sv
module mps_port_ctrl
   import mps_pkg::*;
#(
   parameter int                NUM_PORT   = 3,
   parameter int                NUM_CTRL   = 4,
   parameter int                FIRST_ADDR = 5,
   parameter int                ADDR_W     = 5,
   parameter int                DIR_IDX    = 0,
   parameter logic [WORD_W-1:0] AUX_RST    = '0,
   localparam int PINS   = NUM_PORT * WORD_W,
   localparam int CTRL_W = NUM_PORT * NUM_CTRL * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_vld,
   input  logic [INSTR_W-1:0]   instr,
   input  logic [WORD_W-1:0]    w_in,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic [PINS-1:0]      pin_in,
   input  logic [PINS-1:0]      out_latch,
   output logic [SEL_W-1:0]     mode_q,
   output logic [CTRL_W-1:0]    ctrl_q,
   output logic [PINS-1:0]      pin_oe,
   output logic [PINS-1:0]      pin_dout,
   output logic                 w_we,
   output logic [WORD_W-1:0]    w_wdata,
   output logic                 rd_hit,
   output logic [WORD_W-1:0]    rd_data
);

   if (NUM_CTRL < 1 || NUM_CTRL > (1 << SEL_W)) begin : g_bad_ctrl
      $error("NUM_CTRL must lie in 1..16");
   end
   if (DIR_IDX >= NUM_CTRL) begin : g_bad_dir
      $error("DIR_IDX must select an existing register");
   end
   if (FIRST_ADDR + NUM_PORT > 8 || FIRST_ADDR < 1) begin : g_bad_addr
      $error("port addresses must fit the 3-bit opcode field");
   end
   if ((1 << ADDR_W) < FIRST_ADDR + NUM_PORT) begin : g_bad_aw
      $error("ADDR_W too narrow for port addresses");
   end

   op_t                 op;
   logic [NUM_PORT-1:0] port_wsel;
   logic [PINS-1:0]     dir_all;

   mps_decode #(.NUM_PORT(NUM_PORT), .FIRST_ADDR(FIRST_ADDR)) u_dec (
      .instr_vld (instr_vld),
      .instr     (instr),
      .op        (op),
      .port_wsel (port_wsel)
   );

   mps_mode_reg #(.RST_VAL(SEL_W'(DIR_IDX))) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lit  (op.sel_lit),
      .lit_val (op.sel_lit_val),
      .ld_w    (op.sel_from_w),
      .w_val   (w_in),
      .sel_q   (mode_q)
   );

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      mps_ctrl_bank #(.NUM_CTRL(NUM_CTRL), .DIR_IDX(DIR_IDX), .AUX_RST(AUX_RST)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (port_wsel[p]),
         .sel    (mode_q),
         .wdata  (w_in),
         .regs_q (ctrl_q[p*NUM_CTRL*WORD_W +: NUM_CTRL*WORD_W]),
         .dir_q  (dir_all[p*WORD_W +: WORD_W])
      );
   end

   assign pin_oe   = ~dir_all;
   assign pin_dout = out_latch & ~dir_all;

   assign w_we    = op.sel_to_w;
   assign w_wdata = op.sel_to_w ? {{(WORD_W-SEL_W){1'b0}}, mode_q} : '0;

   mps_read_mux #(.NUM_PORT(NUM_PORT), .FIRST_ADDR(FIRST_ADDR), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr (rd_addr),
      .pin_in  (pin_in),
      .rd_hit  (rd_hit),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/mps_port_ctrl_chk.sv
module mps_port_ctrl_chk
   import mps_pkg::*;
#(
   parameter int NUM_PORT = 3,
   parameter int NUM_CTRL = 4,
   parameter int ADDR_W   = 5,
   parameter int DIR_IDX  = 0
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                instr_vld,
   input logic [INSTR_W-1:0]                  instr,
   input logic [WORD_W-1:0]                   w_in,
   input logic [SEL_W-1:0]                    mode_q,
   input logic [NUM_PORT*NUM_CTRL*WORD_W-1:0] ctrl_q,
   input logic [NUM_PORT*WORD_W-1:0]          pin_oe,
   input logic [NUM_PORT*WORD_W-1:0]          pin_dout,
   input logic                                w_we,
   input logic [WORD_W-1:0]                   w_wdata,
   input logic                                rd_hit,
   input logic [WORD_W-1:0]                   rd_data
);

   logic [NUM_PORT*WORD_W-1:0] dir_v;
   for (genvar p = 0; p < NUM_PORT; p++) begin : g_dir
      assign dir_v[p*WORD_W +: WORD_W] = ctrl_q[(p*NUM_CTRL + DIR_IDX)*WORD_W +: WORD_W];
   end

   logic lit_op, from_w_op;
   assign lit_op    = instr_vld && (instr[11:4] == 8'b0000_0101);
   assign from_w_op = instr_vld && (instr == 12'h043);

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe == ~dir_v) && ((pin_dout & dir_v) == '0)); // R4

   AST_SEL_LIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lit_op |=> mode_q == $past(instr[3:0])); // R5

   AST_SEL_W_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      from_w_op |=> mode_q == $past(w_in[3:0])); // R6

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(lit_op || from_w_op) |=> $stable(mode_q)); // R9

   AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_vld |=> $stable(ctrl_q)); // R9

   AST_SEL_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
      w_we |-> (w_wdata == {4'b0000, mode_q})); // R7

   AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == '0)); // R8

endmodule

bind mps_port_ctrl mps_port_ctrl_chk #(
   .NUM_PORT (NUM_PORT),
   .NUM_CTRL (NUM_CTRL),
   .ADDR_W   (ADDR_W),
   .DIR_IDX  (DIR_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr_vld (instr_vld),
   .instr     (instr),
   .w_in      (w_in),
   .mode_q    (mode_q),
   .ctrl_q    (ctrl_q),
   .pin_oe    (pin_oe),
   .pin_dout  (pin_dout),
   .w_we      (w_we),
   .w_wdata   (w_wdata),
   .rd_hit    (rd_hit),
   .rd_data   (rd_data)
);

// File: tb/sim_mps_port_ctrl.sv
module sim_mps_port_ctrl;

   localparam int NP = 3;
   localparam int NC = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        instr_vld = 0;
   logic [11:0] instr = '0;
   logic [7:0]  w_in = '0;
   logic [4:0]  rd_addr = '0;
   logic [23:0] pin_in = '0;
   logic [23:0] out_latch = '0;
   logic [3:0]  mode_q;
   logic [95:0] ctrl_q;
   logic [23:0] pin_oe, pin_dout;
   logic        w_we;
   logic [7:0]  w_wdata;
   logic        rd_hit;
   logic [7:0]  rd_data;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [3:0] m_mode;
   logic [7:0] m_ctrl [NP][NC];

   always #5 clk = ~clk;

   mps_port_ctrl u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [95:0] exp_ctrl();
      logic [95:0] v = '0;
      for (int p = 0; p < NP; p++)
         for (int r = 0; r < NC; r++) v[(p*NC+r)*8 +: 8] = m_ctrl[p][r];
      return v;
   endfunction

   function automatic logic [23:0] exp_dir();
      logic [23:0] v;
      for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_ctrl[p][0];
      return v;
   endfunction

   function automatic logic [8:0] exp_rd(input logic [4:0] a, input logic [23:0] pins);
      if (a >= 5 && a <= 7) return {1'b1, pins[(a-5)*8 +: 8]};
      return 9'd0;
   endfunction

   task automatic check_state(input string tag);
      chk(ctrl_q == exp_ctrl(), {tag, " R2/R3 ctrl"}, ctrl_q, exp_ctrl());
      chk(mode_q == m_mode, {tag, " R5/R6 mode"}, 96'(mode_q), 96'(m_mode));
      chk(pin_oe == ~exp_dir(), {tag, " R4 oe"}, 96'(pin_oe), 96'(~exp_dir()));
      chk(pin_dout == (out_latch & ~exp_dir()), {tag, " R4 dout"}, 96'(pin_dout),
          96'(out_latch & ~exp_dir()));
   endtask

   task automatic check_read();
      logic [8:0] e = exp_rd(rd_addr, pin_in);
      chk({rd_hit, rd_data} == e, "R8 read", 96'({rd_hit, rd_data}), 96'(e));
   endtask

   // drives one word, checks same-cycle W copy, then the registered result
   task automatic do_op(input bit vld, input logic [11:0] iw, input logic [7:0] w);
      bit  we_e;
      @(negedge clk);
      instr_vld = vld; instr = iw; w_in = w;
      rd_addr = 5'($urandom_range(0, 9));
      pin_in = $urandom; out_latch = $urandom;
      #1;
      we_e = vld && (iw == 12'h042);
      chk(w_we == we_e, "R7 w_we", 96'(w_we), 96'(we_e));
      if (we_e) chk(w_wdata == {4'b0, m_mode}, "R7 w_wdata", 96'(w_wdata), 96'({4'b0, m_mode}));
      check_read();
      if (vld) begin
         if (iw[11:3] == 9'b0 && iw[2:0] >= 5 && m_mode < NC)
            m_ctrl[iw[2:0]-5][m_mode] = w;
         else if (iw[11:4] == 8'h05) m_mode = iw[3:0];
         else if (iw == 12'h043)     m_mode = w[3:0];
      end
      @(posedge clk); #1;
      instr_vld = 0;
      check_state("R9 op");
   endtask

   function automatic logic [11:0] rand_instr();
      case ($urandom_range(0, 5))
         0, 1: return {9'b0, 3'($urandom_range(0, 7))};
         2:    return {8'h05, 4'($urandom_range(0, 5))};
         3:    return 12'h043;
         4:    return 12'h042;
         default: return 12'($urandom);
      endcase
   endfunction

   initial begin
      #(10 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog act=1 exp=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      m_mode = 0;
      for (int p = 0; p < NP; p++)
         for (int r = 0; r < NC; r++) m_ctrl[p][r] = (r == 0) ? 8'hFF : 8'h00;
      repeat (3) @(posedge clk);
      #1;
      check_state("R1 reset");
      chk(pin_oe == '0, "R1 all hi-z", 96'(pin_oe), 96'(0));
      @(negedge clk); rst_n = 1;

      // R2 directed: direction write on each port
      do_op(1, 12'h005, 8'h0F);
      do_op(1, 12'h006, 8'hA5);
      do_op(1, 12'h007, 8'h00);
      // R5 then aux register write
      do_op(1, 12'h052, 8'h00);
      do_op(1, 12'h006, 8'h3C);
      // R3: selector out of range, then f out of range
      do_op(1, 12'h059, 8'h00);
      do_op(1, 12'h005, 8'h77);
      do_op(1, 12'h050, 8'h00);
      do_op(1, 12'h004, 8'h11);
      // R6: W high nibble discarded
      do_op(1, 12'h043, 8'hF3);
      do_op(1, 12'h042, 8'h00);
      // R9: invalid strobe ignored
      do_op(0, 12'h007, 8'h99);
      do_op(0, 12'h05F, 8'h00);
      // R8: pins differ from latch
      @(negedge clk);
      rd_addr = 5'd6; pin_in = 24'h12_00_FF; out_latch = 24'hFF_FF_00;
      #1;
      chk(rd_data == 8'h00 && rd_hit, "R8 pin low latch high", 96'(rd_data), 96'(0));

      for (int i = 0; i < 400; i++)
         do_op($urandom_range(0, 9) != 0, rand_instr(), 8'($urandom));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule